// File: doc/BRIEF.md
# Single-Wire Bus Slave Responder

This block is the physical layer of a slave on a single-wire open-drain bus. It watches the shared line through a two-flop synchronizer and measures every low period against a microsecond tick. A low that lasts long enough counts as a bus reset. After the master lets the line go high again, the slave waits a fixed delay and then pulls the line low for a fixed time to announce that it is present.

Every other low period starts a time slot. On the synchronized falling edge, the slave latches the slot type and the bit it will send, then starts its own delay timer. That timer sets two things. In a write slot it sets the moment at which the line is sampled and a received bit is strobed out. In a read slot sending zero it sets how long the slave holds the line low. A read slot sending one never drives the line. Command decoding sits above this block and feeds it the slot type and the transmit bit.

Top module: `owire_slave_phy`

## Requirements
- R1: After rst_ni is released, pull_low_o and rx_valid_o are both 0.
- R2: A synchronized low lasting at least RST_MIN_US (480) microsecond ticks is a bus reset. A low of 400 us is not a reset and produces no presence pulse. The slave never pulls the line while the master holds a reset low.
- R3: After the rising edge that ends a reset, the slave waits PD_WAIT_US (30) ticks before asserting pull_low_o, with one tick of tolerance for synchronizer delay.
- R4: The presence pulse keeps pull_low_o high for exactly PD_LOW_US (120) ticks.
- R5: In a write slot (slot_is_read_i = 0), rx_valid_o pulses for one clock SAMPLE_US (30) ticks after the falling edge, exactly once per slot. rx_bit_o then equals the line level: 0 if the master is still holding the line low, 1 if it has released it. A write slot never drives the line.
- R6: In a read slot (slot_is_read_i = 1) with tx_bit_i = 0, pull_low_o is high for exactly HOLD_US (30) ticks from the falling edge. A master that samples 12 us into the slot reads 0. No rx_valid_o pulse is produced.
- R7: In a read slot with tx_bit_i = 1, pull_low_o stays 0 for the whole slot. The master reads 1 and no rx_valid_o pulse is produced.
- R8: A reset detected during a slot aborts that slot, and the presence sequence of R3 and R4 follows the end of the reset.
- R9: slot_is_read_i and tx_bit_i are captured at the falling edge. Changing tx_bit_i later in the slot has no effect on that slot's line behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| us_tick_i | input | 1 | One-clock pulse once per microsecond |
| line_i | input | 1 | Bus line level (asynchronous) |
| slot_is_read_i | input | 1 | 1: next slot is a read (slave sends), 0: write (slave receives) |
| tx_bit_i | input | 1 | Bit to send in a read slot |
| pull_low_o | output | 1 | Open-drain pull-down enable |
| rx_valid_o | output | 1 | One-clock strobe for a received bit |
| rx_bit_o | output | 1 | Received bit value, valid with rx_valid_o |

## Verification
The assertions assume three things about the inputs. us_tick_i is a single-clock pulse with at least a few clocks between pulses. Every low period on the line lasts longer than the synchronizer latency. The master does not start a new slot while the slave is still holding the line low. The stimulus meets all three: it drives the tick every fourth clock, one nanosecond after the clock edge. It moves the master's side of the wired-AND line only on falling clock edges and only in whole microseconds. It always leaves a recovery gap after the slave releases the line before the next falling edge.

// File: rtl/owire_pkg.sv
package owire_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RST, ST_PD_WAIT, ST_PD_LOW, ST_PD_REL, ST_WR, ST_RD0, ST_END
  } slot_st_e;
endpackage

// File: rtl/owire_line_sync.sv
module owire_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o,
  output logic fall_o,
  output logic rise_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= line_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign line_o = s2_q;
  assign fall_o = prev_q & ~s2_q;
  assign rise_o = ~prev_q & s2_q;
endmodule

// File: rtl/owire_low_meter.sv
module owire_low_meter #(
  parameter int RST_MIN_US = 480
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic us_tick_i,
  input  logic line_i,
  output logic rst_det_o
);
  localparam int CW = $clog2(RST_MIN_US + 1);
  localparam logic [CW-1:0] LIM = CW'(RST_MIN_US);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (line_i)                  cnt_q <= '0;
    else if (us_tick_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign rst_det_o = ~line_i & (cnt_q == LIM);

  // count only builds up over a low line
  assert_low_before_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_det_o |-> $past(!line_i));
endmodule

// File: rtl/owire_slot_fsm.sv
module owire_slot_fsm
  import owire_pkg::*;
#(
  parameter int PD_WAIT_US = 30,
  parameter int PD_LOW_US  = 120,
  parameter int SAMPLE_US  = 30,
  parameter int HOLD_US    = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic us_tick_i,
  input  logic line_i,
  input  logic fall_i,
  input  logic rise_i,
  input  logic rst_det_i,
  input  logic slot_is_read_i,
  input  logic tx_bit_i,
  output logic pull_low_o,
  output logic rx_valid_o,
  output logic rx_bit_o
);
  localparam int T1   = (PD_WAIT_US > PD_LOW_US) ? PD_WAIT_US : PD_LOW_US;
  localparam int T2   = (SAMPLE_US > HOLD_US) ? SAMPLE_US : HOLD_US;
  localparam int TMAX = (T1 > T2) ? T1 : T2;
  localparam int TW   = $clog2(TMAX + 1);

  slot_st_e      st_q;
  logic [TW-1:0] tmr_q;
  logic [TW-1:0] last_c;
  slot_st_e      nxt_c;
  logic          timed_c;

  always_comb begin
    timed_c = 1'b1;
    last_c  = '0;
    nxt_c   = ST_END;
    unique case (st_q)
      ST_PD_WAIT: begin last_c = TW'(PD_WAIT_US - 1); nxt_c = ST_PD_LOW; end
      ST_PD_LOW:  begin last_c = TW'(PD_LOW_US - 1);  nxt_c = ST_PD_REL; end
      ST_WR:      last_c = TW'(SAMPLE_US - 1);
      ST_RD0:     last_c = TW'(HOLD_US - 1);
      default:    timed_c = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      tmr_q      <= '0;
      rx_valid_o <= 1'b0;
      rx_bit_o   <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (rst_det_i && st_q != ST_RST) begin
        st_q  <= ST_RST;  // abort whatever is running
        tmr_q <= '0;
      end else if (timed_c) begin
        if (us_tick_i) begin
          if (tmr_q == last_c) begin
            tmr_q <= '0;
            st_q  <= nxt_c;
            if (st_q == ST_WR) begin
              rx_valid_o <= 1'b1;
              rx_bit_o   <= line_i;
            end
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
      end else begin
        unique case (st_q)
          ST_IDLE: if (fall_i) begin
            tmr_q <= '0;
            if (!slot_is_read_i) st_q <= ST_WR;
            else if (tx_bit_i)   st_q <= ST_END;
            else                 st_q <= ST_RD0;
          end
          ST_RST: if (rise_i) begin
            tmr_q <= '0;
            st_q  <= ST_PD_WAIT;
          end
          default: if (line_i) st_q <= ST_IDLE;  // PD_REL, END
        endcase
      end
    end
  end

  assign pull_low_o = (st_q == ST_PD_LOW) || (st_q == ST_RD0);

  assert_strobe_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  assert_rx_on_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(us_tick_i));
  assert_presence_after_wait_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pull_low_o) && st_q == ST_PD_LOW) |-> $past(st_q) == ST_PD_WAIT);
  assert_release_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pull_low_o) && !$past(rst_det_i) |-> $past(us_tick_i));
  assert_read_one_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && fall_i && slot_is_read_i && tx_bit_i && !rst_det_i) |=> !pull_low_o);
  assert_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_det_i |=> st_q == ST_RST);
endmodule

// File: rtl/owire_slave_phy.sv
module owire_slave_phy #(
  parameter int RST_MIN_US = 480,
  parameter int PD_WAIT_US = 30,
  parameter int PD_LOW_US  = 120,
  parameter int SAMPLE_US  = 30,
  parameter int HOLD_US    = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic us_tick_i,
  input  logic line_i,
  input  logic slot_is_read_i,
  input  logic tx_bit_i,
  output logic pull_low_o,
  output logic rx_valid_o,
  output logic rx_bit_o
);
  logic line_s, fall_s, rise_s, rst_det;

  owire_line_sync u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .line_i(line_i),
    .line_o(line_s), .fall_o(fall_s), .rise_o(rise_s)
  );

  owire_low_meter #(.RST_MIN_US(RST_MIN_US)) u_meter (
    .clk_i(clk_i), .rst_ni(rst_ni), .us_tick_i(us_tick_i),
    .line_i(line_s), .rst_det_o(rst_det)
  );

  owire_slot_fsm #(
    .PD_WAIT_US(PD_WAIT_US), .PD_LOW_US(PD_LOW_US),
    .SAMPLE_US(SAMPLE_US), .HOLD_US(HOLD_US)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .us_tick_i(us_tick_i),
    .line_i(line_s), .fall_i(fall_s), .rise_i(rise_s), .rst_det_i(rst_det),
    .slot_is_read_i(slot_is_read_i), .tx_bit_i(tx_bit_i),
    .pull_low_o(pull_low_o), .rx_valid_o(rx_valid_o), .rx_bit_o(rx_bit_o)
  );

  // a reset low can never coexist with the slave driving
  assert_quiet_in_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_det |=> !pull_low_o);
endmodule

// File: tb/tb_owire_slave_phy.sv
module tb_owire_slave_phy;
  localparam int PD_WAIT = 30;
  localparam int PD_LOW  = 120;
  localparam int HOLD    = 30;
  localparam int CPU     = 4;  // clocks per microsecond

  // {is_read, tx_bit, master_bit}
  localparam logic [2:0] VEC [8] = '{
    3'b001, 3'b000, 3'b100, 3'b110, 3'b000, 3'b110, 3'b100, 3'b001
  };

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, line_m = 1'b1;
  logic rd = 1'b0, txb = 1'b0;
  logic pull, rxv, rxb, line_w;
  int n_chk = 0, n_fail = 0, rx_cnt = 0, pull_ticks = 0;
  logic rx_last = 1'b0;

  always #4 clk = ~clk;
  assign line_w = line_m & ~pull;

  owire_slave_phy dut (
    .clk_i(clk), .rst_ni(rst_n), .us_tick_i(tick), .line_i(line_w),
    .slot_is_read_i(rd), .tx_bit_i(txb),
    .pull_low_o(pull), .rx_valid_o(rxv), .rx_bit_o(rxb)
  );

  initial begin
    int c = 0;
    forever begin
      @(posedge clk); #1;
      tick = (c == CPU - 1);
      c = (c == CPU - 1) ? 0 : c + 1;
    end
  end

  always @(negedge clk) begin
    if (rxv) begin rx_cnt++; rx_last = rxb; end
    if (pull && tick) pull_ticks++;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wait_us(input int n);
    repeat (n * CPU) @(negedge clk);
  endtask

  // called at the moment the master releases a reset low
  task automatic check_presence(input string req);
    int w = 0, p = 0, guard = 0;
    while (!pull && guard < 400 * CPU) begin
      @(negedge clk);
      if (!pull && tick) w++;
      guard++;
    end
    chk(w >= PD_WAIT && w <= PD_WAIT + 1, {req, " R3 wait"}, w, PD_WAIT);
    guard = 0;
    while (pull && guard < 400 * CPU) begin
      if (tick) p++;
      @(negedge clk);
      guard++;
    end
    chk(p == PD_LOW, {req, " R4 width"}, p, PD_LOW);
    wait_us(20);
  endtask

  task automatic master_reset(input int low_us, input string req);
    @(negedge clk); line_m = 1'b0;
    pull_ticks = 0;
    wait_us(low_us);
    chk(pull_ticks == 0, {req, " R2 quiet"}, pull_ticks, 0);
    line_m = 1'b1;
    check_presence(req);
  endtask

  task automatic do_slot(input logic is_rd, input logic tx, input logic mb);
    int hold;
    logic seen;
    hold = (!is_rd && !mb) ? 60 : 2;
    rd = is_rd; txb = tx;
    rx_cnt = 0; pull_ticks = 0; seen = 1'b1;
    @(negedge clk); line_m = 1'b0;
    wait_us(1);
    txb = ~tx;                 // R9: late change must be ignored
    wait_us(hold - 1);
    line_m = 1'b1;
    if (is_rd) begin
      wait_us(10);
      seen = line_w;
      wait_us(63 - hold);
    end else begin
      wait_us(73 - hold);
    end
    if (is_rd) begin
      chk(seen == tx, tx ? "R7 R9 read bit" : "R6 R9 read bit", seen, tx);
      chk(pull_ticks == (tx ? 0 : HOLD), tx ? "R7 no pull" : "R6 hold width",
          pull_ticks, tx ? 0 : HOLD);
      chk(rx_cnt == 0, "R6 no strobe on read", rx_cnt, 0);
    end else begin
      chk(rx_cnt == 1 && rx_last == mb, "R5 write capture", rx_last, mb);
      chk(pull_ticks == 0, "R5 write no pull", pull_ticks, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pull == 1'b0, "R1 pull after reset", pull, 0);
    chk(rxv == 1'b0, "R1 strobe after reset", rxv, 0);

    master_reset(500, "R2 initial reset");

    for (int i = 0; i < 8; i++) begin
      do_slot(VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R2: a 400 us low is a long write-0, not a reset
    rd = 1'b0; pull_ticks = 0; rx_cnt = 0;
    @(negedge clk); line_m = 1'b0;
    wait_us(400);
    line_m = 1'b1;
    wait_us(200);
    chk(pull_ticks == 0, "R2 400us low gives no presence", pull_ticks, 0);
    chk(rx_cnt == 1 && rx_last == 1'b0, "R2 400us low is a write-0", rx_last, 0);

    // R8: reset overlapping a read-0 slot
    rd = 1'b1; txb = 1'b0; pull_ticks = 0;
    @(negedge clk); line_m = 1'b0;
    wait_us(500);
    chk(pull_ticks == HOLD, "R8 slot hold before abort", pull_ticks, HOLD);
    line_m = 1'b1;
    check_presence("R8 abort read");

    // R8: reset overlapping a write slot, then a clean slot afterwards
    rd = 1'b0;
    master_reset(520, "R8 abort write");
    do_slot(1'b0, 1'b0, 1'b1);

    finish_run();
  end
endmodule